// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Refresh

This block is a watchdog that counts down from a selectable power-of-two period, one count per tick of an internal prescaler. Software keeps it from expiring by writing a fixed two-word key pair to a refresh register. A refresh is honoured only while the counter sits inside an enabled part of its range. The range is cut into four quarters, and any nonempty combination of them can be enabled.

The counter does not run after reset. The first complete key pair starts it. From then on the control word is frozen until the next reset. If the counter runs out, or if a key pair completes outside the enabled quarters, a sticky status flag is raised. A configured event is raised with it: either a level interrupt request or a one-cycle reset request. A control bit decides whether counting pauses while the low-power indication is high.

Access goes through a small single-cycle write/read port with three registers. Address 0 is control. Address 1 is the refresh register on write and the current count on read. Address 2 is status.

Top module: `wdog_win`

## Requirements
- R1: After reset the control word, the status flags, the count read at address 1, irq_o and rst_req_o are all zero.
- R2: A refresh is a write of 0x0123 to address 1 followed by a write of 0x3210 as the very next write to address 1. Any other value written to address 1, including a repeated 0x0123, cancels the half-finished pair. Writes to other addresses leave the pair intact.
- R3: Until the first refresh the counter stays idle at 0. That refresh loads period-1 without any window check.
- R4: Control bits [1:0] select the period: 0 gives 256, 1 gives 4096, 2 gives 16384 and 3 gives 65536 counts.
- R5: Control bits [4:2] select the clock divider: 4, 64, 128, 256, 512, 1024, 2048 or 8192 for codes 0 to 7. The count drops by one every divider clocks, and the first decrement comes one divider interval after the load.
- R6: Control bits [8:5] form a window mask with one bit per quarter. Bit 0 covers the top quarter (count from period-1 down to 3/4 of the period), bit 1 the next quarter, bit 2 the next, and bit 3 the bottom quarter (counts below 1/4 of the period).
- R7: A refresh while running, with the count in an enabled quarter, reloads period-1 and restarts the prescaler.
- R8: A refresh while running, with the count outside the enabled quarters, sets status bit 1 and raises the event. The count is not reloaded.
- R9: A tick at count 0 sets status bit 0, raises the event and reloads period-1. Counting goes on.
- R10: Control bit 10 selects the event. When it is 0, irq_o is high while any status flag is set. When it is 1, rst_req_o pulses for one cycle per event and irq_o stays low.
- R11: Writing 1 to a status bit at address 2 clears that flag. A new event in the same cycle wins over the clear.
- R12: With control bit 9 set, the prescaler and counter hold while lp_i is high. With bit 9 clear, lp_i has no effect.
- R13: Once the counter has started, writes to address 0 are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address for write and read |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| lp_i | input | 1 | Low-power indication |
| irq_o | output | 1 | Interrupt request (level) |
| rst_req_o | output | 1 | Reset request (one-cycle pulse) |

## Verification
The assertions assume lp_i and the write port are synchronous to clk_i and change only between edges. They also assume software never uses the illegal all-zero window mask. The reset-request exclusivity check further relies on the event selection staying frozen from start onwards, so the control word is written only before the first key pair. The bench keeps to these assumptions. It drives every input on the falling edge and writes each control word once after reset, always with a nonempty mask. It reconfigures only through a fresh reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_KICK = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam logic [15:0] KEY_FIRST  = 16'h0123;
  localparam logic [15:0] KEY_SECOND = 16'h3210;

  typedef struct packed {
    logic       evt_rst;   // 1: reset request, 0: interrupt
    logic       lp_stop;   // hold count while lp_i
    logic [3:0] win_mask;  // bit q enables quarter q (q0 = top)
    logic [2:0] pre_sel;
    logic [1:0] per_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [4:0] pre_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 5'd2;
      3'd1:    return 5'd6;
      3'd2:    return 5'd7;
      3'd3:    return 5'd8;
      3'd4:    return 5'd9;
      3'd5:    return 5'd10;
      3'd6:    return 5'd11;
      default: return 5'd13;
    endcase
  endfunction

  function automatic logic [4:0] per_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd8;
      2'd1:    return 5'd12;
      2'd2:    return 5'd14;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kick_wr_i,
  input  logic [DATA_W-1:0] kick_data_i,
  output logic              refresh_o
);
  import wdog_pkg::*;

  logic armed_q;

  // any write that is not the expected next key drops back to the first key
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (kick_wr_i) armed_q <= !armed_q && (kick_data_i == DATA_W'(KEY_FIRST));
  end

  assign refresh_o = kick_wr_i && armed_q && (kick_data_i == DATA_W'(KEY_SECOND));

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W = 13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic [4:0] shift_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   div_oh;
  logic [PRE_W-1:0] last;

  assign div_oh = (PRE_W+1)'(1) << shift_i;
  assign last   = PRE_W'(div_oh - 1'b1);
  assign tick_o = en_i && (pre_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else if (en_i)   pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [4:0]       shift_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o,
  output logic [1:0]       quarter_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   per_oh;
  logic [CNT_W-1:0] reload;
  logic [1:0]       top_bits;

  assign per_oh   = (CNT_W+1)'(1) << shift_i;
  assign reload   = CNT_W'(per_oh - 1'b1);
  assign top_bits = 2'(cnt_q >> (shift_i - 5'd2));
  // quarter 0 is the top of the range
  assign quarter_o = ~top_bits;
  assign uf_o      = tick_i && !load_i && (cnt_q == '0);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= reload;
    else if (tick_i)  cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
  end

endmodule

// File: rtl/wdog_win.sv
module wdog_win #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              lp_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  import wdog_pkg::*;

  ctrl_t            ctrl_q;
  logic             running_q, uf_q, err_q, rst_req_q;
  logic             refresh, start, in_win, ok_refresh, bad_refresh;
  logic             load, tick, cnt_en, uf_evt, evt, stat_wr;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       quarter;

  wdog_keyseq #(.DATA_W(DATA_W)) u_keyseq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kick_wr_i   (wr_i && (addr_i == ADDR_KICK)),
    .kick_data_i (wdata_i),
    .refresh_o   (refresh)
  );

  assign start       = refresh && !running_q;
  assign in_win      = ctrl_q.win_mask[quarter];
  assign ok_refresh  = refresh && running_q && in_win;
  assign bad_refresh = refresh && running_q && !in_win;
  assign load        = start || ok_refresh;
  assign cnt_en      = running_q && !(lp_i && ctrl_q.lp_stop);

  wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cnt_en),
    .clr_i   (load),
    .shift_i (pre_shift(ctrl_q.pre_sel)),
    .tick_o  (tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .tick_i    (tick),
    .shift_i   (per_shift(ctrl_q.per_sel)),
    .cnt_o     (cnt),
    .uf_o      (uf_evt),
    .quarter_o (quarter)
  );

  assign evt     = uf_evt || bad_refresh;
  assign stat_wr = wr_i && (addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      running_q <= 1'b0;
      uf_q      <= 1'b0;
      err_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (wr_i && (addr_i == ADDR_CTRL) && !running_q)
        ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (start) running_q <= 1'b1;
      // set wins over write-one-to-clear
      uf_q      <= uf_evt      || (uf_q  && !(stat_wr && wdata_i[0]));
      err_q     <= bad_refresh || (err_q && !(stat_wr && wdata_i[1]));
      rst_req_q <= evt && ctrl_q.evt_rst;
    end
  end

  assign irq_o     = (uf_q || err_q) && !ctrl_q.evt_rst;
  assign rst_req_o = rst_req_q;

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = DATA_W'(ctrl_q);
      ADDR_KICK: rdata_o = DATA_W'(cnt);
      ADDR_STAT: rdata_o = DATA_W'({err_q, uf_q});
      default:   rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/wdog_win_chk.sv
module wdog_win_chk #(
  parameter int CNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic [1:0]         addr_i,
  input logic               wdata0_i,
  input logic               lp_i,
  input logic               irq_o,
  input logic               rst_req_o,
  input logic               running_q,
  input logic [CNT_W-1:0]   cnt,
  input wdog_pkg::ctrl_t    ctrl_q,
  input logic               uf_q,
  input logic               uf_evt,
  input logic               refresh
);
  import wdog_pkg::*;

  logic [CNT_W:0]   per_oh;
  logic [CNT_W-1:0] top_val;
  assign per_oh  = (CNT_W+1)'(1) << per_shift(ctrl_q.per_sel);
  assign top_val = CNT_W'(per_oh - 1'b1);

  // R13
  cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |=> $stable(ctrl_q));

  // R3
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_q |-> (cnt == '0));

  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && $past(running_q) && !$stable(cnt)) |->
      ((cnt == $past(cnt) - 1'b1) || (cnt == top_val)));

  // R12
  lp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && lp_i && ctrl_q.lp_stop && !refresh) |=> $stable(cnt));

  // R10
  evt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !irq_o);

  // R11
  uf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == ADDR_STAT) && wdata0_i && !uf_evt) |=> !uf_q);

  // R9
  uf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_evt |=> (uf_q && (cnt == top_val)));

endmodule

bind wdog_win wdog_win_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata0_i  (wdata_i[0]),
  .lp_i      (lp_i),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .running_q (running_q),
  .cnt       (cnt),
  .ctrl_q    (ctrl_q),
  .uf_q      (uf_q),
  .uf_evt    (uf_evt),
  .refresh   (refresh)
);

// File: tb/tb_wdog_win.sv
module tb_wdog_win;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        lp_i = 1'b0;
  logic        irq_o, rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] v;

  always #5 clk_i = ~clk_i;

  wdog_win dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .lp_i(lp_i),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  typedef struct packed {
    logic [1:0]  per;
    logic [2:0]  pre;
    logic [15:0] wait_n;
    logic [15:0] exp_cnt;
  } vec_t;

  localparam int VN = 9;
  // expected = period-1 - floor(wait/divider)
  localparam vec_t VEC [VN] = '{
    '{2'd0, 3'd0, 16'd100,  16'd230},
    '{2'd1, 3'd0, 16'd40,   16'd4085},
    '{2'd2, 3'd1, 16'd640,  16'd16373},
    '{2'd3, 3'd2, 16'd1280, 16'd65525},
    '{2'd0, 3'd3, 16'd2560, 16'd245},
    '{2'd0, 3'd4, 16'd5120, 16'd245},
    '{2'd0, 3'd5, 16'd1024, 16'd254},
    '{2'd0, 3'd6, 16'd4096, 16'd253},
    '{2'd0, 3'd7, 16'd8192, 16'd254}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input int per, input int pre, input int mask,
                                     input int lp, input int ev);
    return {5'b0, ev[0], lp[0], mask[3:0], pre[2:0], per[1:0]};
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_i = 1'b0; lp_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic kick();
    wr(2'd1, 16'h0123);
    wr(2'd1, 16'h3210);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // table: period and divider encodings, R4 R5
    for (int i = 0; i < VN; i++) begin
      do_reset();
      wr(2'd0, cw(VEC[i].per, VEC[i].pre, 15, 0, 0));
      kick();
      repeat (VEC[i].wait_n) @(negedge clk_i);
      rd(2'd1, v);
      chk($sformatf("R4 R5 vec%0d count", i), v, VEC[i].exp_cnt);
    end

    // R1 reset state
    do_reset();
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd2, v); chk("R1 status", v, 0);
    rd(2'd1, v); chk("R1 count", v, 0);
    chk("R1 irq_o", irq_o, 0);
    chk("R1 rst_req_o", rst_req_o, 0);

    // R3 idle until first refresh
    wr(2'd0, cw(0, 0, 15, 0, 0));
    rd(2'd0, v); chk("R13 ctrl written while idle", v, cw(0, 0, 15, 0, 0));
    repeat (50) @(negedge clk_i);
    rd(2'd1, v); chk("R3 idle count", v, 0);

    // R2 key sequence
    wr(2'd1, 16'h3210);
    rd(2'd1, v); chk("R2 second key alone", v, 0);
    wr(2'd1, 16'h0123); wr(2'd1, 16'h0123); wr(2'd1, 16'h3210);
    rd(2'd1, v); chk("R2 repeated first key", v, 0);
    wr(2'd1, 16'h0123); wr(2'd1, 16'h5555); wr(2'd1, 16'h3210);
    rd(2'd1, v); chk("R2 foreign value", v, 0);
    wr(2'd1, 16'h0123); wr(2'd2, 16'h0000); wr(2'd1, 16'h3210);
    rd(2'd1, v); chk("R2 R3 start loads period-1", v, 255);

    // R13 lock (N=1 after start)
    wr(2'd0, cw(3, 7, 1, 1, 1));
    rd(2'd0, v); chk("R13 ctrl locked", v, cw(0, 0, 15, 0, 0));

    // R9 underflow at 4*256 cycles after start
    repeat (1022) @(negedge clk_i);
    rd(2'd2, v); chk("R9 no underflow yet", v, 0);
    @(negedge clk_i);
    rd(2'd2, v); chk("R9 underflow flag", v, 1);
    rd(2'd1, v); chk("R9 reload after underflow", v, 255);
    chk("R10 irq_o level", irq_o, 1);
    chk("R10 rst_req_o quiet", rst_req_o, 0);

    // R11 clear
    wr(2'd2, 16'h0001);
    rd(2'd2, v); chk("R11 flag cleared", v, 0);
    chk("R11 irq_o drops", irq_o, 0);

    // R7 reload restarts prescaler
    kick();
    rd(2'd1, v); chk("R7 reload", v, 255);
    repeat (6) @(negedge clk_i);
    rd(2'd1, v); chk("R7 prescaler restarted", v, 254);

    // R6 R8 R10 top-quarter window, reset event
    do_reset();
    wr(2'd0, cw(0, 0, 1, 0, 1));
    kick();
    kick();
    rd(2'd1, v); chk("R7 refresh in quarter 0", v, 255);
    repeat (300) @(negedge clk_i);
    kick();
    rd(2'd2, v); chk("R8 error flag", v, 2);
    rd(2'd1, v); chk("R8 no reload", v, 180);
    chk("R10 rst_req_o pulse", rst_req_o, 1);
    chk("R10 irq_o low with reset event", irq_o, 0);
    @(negedge clk_i);
    chk("R10 rst_req_o single cycle", rst_req_o, 0);

    // R6 union of quarters 1 and 3
    do_reset();
    wr(2'd0, cw(0, 0, 4'b1010, 0, 0));
    kick();
    kick();
    rd(2'd2, v); chk("R6 quarter 0 rejected", v, 2);
    rd(2'd1, v); chk("R8 count kept", v, 255);
    chk("R10 irq_o on error", irq_o, 1);
    wr(2'd2, 16'h0002);
    rd(2'd2, v); chk("R11 error flag cleared", v, 0);
    repeat (296) @(negedge clk_i);
    kick();
    rd(2'd1, v); chk("R6 quarter 1 accepted", v, 255);
    rd(2'd2, v); chk("R6 no error in quarter 1", v, 0);
    repeat (619) @(negedge clk_i);
    kick();
    rd(2'd2, v); chk("R6 quarter 2 rejected", v, 2);

    // R12 low-power stop
    do_reset();
    wr(2'd0, cw(0, 0, 15, 1, 0));
    kick();
    lp_i = 1'b1;
    repeat (100) @(negedge clk_i);
    rd(2'd1, v); chk("R12 held in low power", v, 255);
    lp_i = 1'b0;
    repeat (40) @(negedge clk_i);
    rd(2'd1, v); chk("R12 resumes", v, 245);

    do_reset();
    wr(2'd0, cw(0, 0, 15, 0, 0));
    kick();
    lp_i = 1'b1;
    repeat (40) @(negedge clk_i);
    rd(2'd1, v); chk("R12 lp_i ignored when bit clear", v, 245);
    lp_i = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule